// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Receive and Transmit Queues

This block is an asynchronous serial transmitter and receiver that sits on a simple synchronous register bus. Software writes characters into a transmit queue and reads received characters from a receive queue through one data register. Every received character carries its own error bits. These bits are exposed in a separate status register, which refers to the character most recently read. A 12-bit divisor, split over two registers, sets the bit rate. Every bit lasts 16 ticks, and a tick comes once every divisor+1 clocks.

The frame format is programmable. Software chooses 5 to 8 data bits, no parity or odd or even parity, and one or two stop bits. It can also enable or disable the queues and force a break on the line. Two level interrupt outputs tell software that received data is waiting or that the transmit queue has room. Both interrupts are gated by an enable register. Software clears the enable register before it reprograms the bit rate or the frame format.

Top module: `sio_uart`

## Requirements
- R1: The bit time is 16 × (div+1) clocks, where div is a 12-bit value. Bits 7:0 are at address 3 and bits 11:8 are in bits 3:0 of address 4. Upper bits of address 4 read as zero.
- R2: The line-control register is at address 5. Bits 6:5 give the data length (00=5, 01=6, 10=7, 11=8 bits). Bit 1 enables parity, bit 2 selects even parity (odd when clear), and bit 3 selects two stop bits. A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then high stop bits.
- R3: A write to address 0 queues a transmit character. A read of address 0 returns and removes the oldest received character, with unused upper bits zero. A read while the receive queue is empty returns 0 and changes nothing.
- R4: Address 1 gives the errors of the character most recently read from address 0: bit 0 framing, bit 1 parity, bit 2 overrun.
- R5: Address 2 holds the flags: bit 3 transmitter shifting, bit 4 receive queue empty, bit 5 transmit queue full. All other bits read as 0.
- R6: When bit 4 of line control is set, each queue holds 16 characters. When it is clear, each queue holds 1 character. A write to a full transmit queue is dropped.
- R7: A frame that completes while the receive queue is full is discarded. The newest stored character gets its overrun bit set.
- R8: A low pulse on the receive line that is gone by the middle of the start bit is rejected, and no character is received.
- R9: A stop bit sampled low sets the framing bit. A parity bit that disagrees with the selected parity sets the parity bit. The character is still stored.
- R10: While bit 0 of line control is set, the transmit line is low and no new character starts. Queued characters go out once the bit clears.
- R11: Address 6 bit 0 enables the port. While it is 0, no transmit frame starts, the receiver ignores the line, and both interrupts are low.
- R12: rx_irq_o is high while the port is enabled and the receive queue is not empty. tx_irq_o is high while the port is enabled and the transmit queue is not full.
- R13: After reset, all control registers read 0, tx_o is high, the flags read 0x10, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe, one cycle per access |
| wr_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| rx_irq_o | output | 1 | Receive data waiting |
| tx_irq_o | output | 1 | Transmit queue has room |

## Verification
The bench builds the block with its default parameters: 16-entry queues, a 12-bit divisor and 16 ticks per bit. With a divisor of 0, every frame takes only 16 clocks per bit. This makes it affordable to sweep all 24 frame formats, to fill both queues completely and to push them into overrun. Two runs at larger divisors, one of them using the middle divisor register, check the bit-time formula. A bench-driven receive line carries the corrupted parity bits, low stop bits and short glitches that loopback cannot produce.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } ser_st_e;

  // line-control register, bit 6 down to bit 0
  typedef struct packed {
    logic [1:0] wlen;
    logic       fifo_en;
    logic       two_stop;
    logic       even;
    logic       par_en;
    logic       brk;
  } lctl_t;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_FLAG = 3'd2;
  localparam logic [2:0] A_DIVL = 3'd3;
  localparam logic [2:0] A_DIVM = 3'd4;
  localparam logic [2:0] A_LCTL = 3'd5;
  localparam logic [2:0] A_EN   = 3'd6;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W = 8,
  parameter int D = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         one_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  input  logic         mark_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;
  localparam int CW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [AW-1:0] wptr_q, rptr_q, wprev;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = one_i ? !empty_o : (cnt_q == CW'(D));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem[rptr_q];
  assign wprev   = (wptr_q == '0) ? AW'(D - 1) : wptr_q - 1'b1;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(D - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wptr_q] <= din_i;
    else if (mark_i && !empty_o) mem[wprev][W-1] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r6_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q));
  a_r7_mark_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && !push_i && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       brk_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       even_i,
  input  logic       two_stop_i,
  input  logic       avail_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       tx_o,
  output logic       busy_o
);
  localparam int TCW = $clog2(OVS);

  ser_st_e        st_q;
  logic [TCW-1:0] tcnt_q;
  logic [2:0]     idx_q, last_idx;
  logic [7:0]     sh_q, mask;
  logic           stop2_q, bit_end, par_bit, line;

  assign last_idx = {1'b0, wlen_i} + 3'd4;
  assign mask     = 8'hFF >> (2'd3 - wlen_i);
  assign par_bit  = (^(sh_q & mask)) ^ ~even_i;
  assign bit_end  = tick_i && (tcnt_q == TCW'(OVS - 1));
  assign pop_o    = (st_q == ST_IDLE) && en_i && !brk_i && avail_i;
  assign busy_o   = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      stop2_q <= 1'b0;
    end else if (!en_i) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
    end else if (pop_o) begin
      st_q    <= ST_START;
      sh_q    <= data_i;
      tcnt_q  <= '0;
      idx_q   <= '0;
      stop2_q <= 1'b0;
    end else if (tick_i && st_q != ST_IDLE) begin
      tcnt_q <= bit_end ? '0 : tcnt_q + 1'b1;
      if (bit_end) begin
        case (st_q)
          ST_START: st_q <= ST_DATA;
          ST_DATA: begin
            if (idx_q == last_idx) st_q <= par_en_i ? ST_PAR : ST_STOP;
            else idx_q <= idx_q + 1'b1;
          end
          ST_PAR: st_q <= ST_STOP;
          ST_STOP: begin
            if (two_stop_i && !stop2_q) stop2_q <= 1'b1;
            else st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[idx_q];
      ST_PAR:   line = par_bit;
      default:  line = 1'b1;
    endcase
  end
  assign tx_o = line & ~brk_i;

  a_r10_no_start_in_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && brk_i) |=> (st_q == ST_IDLE));
  a_r2_pop_starts_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> busy_o);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       even_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       frm_o,
  output logic       perr_o
);
  localparam int TCW  = $clog2(OVS);
  localparam int HALF = OVS / 2;

  ser_st_e        st_q;
  logic [TCW-1:0] tcnt_q;
  logic [2:0]     idx_q, last_idx;
  logic [1:0]     sync_q;
  logic           prev_q, line, bit_end, mid_end;

  assign line     = sync_q[1];
  assign last_idx = {1'b0, wlen_i} + 3'd4;
  assign bit_end  = tick_i && (tcnt_q == TCW'(OVS - 1));
  assign mid_end  = tick_i && (tcnt_q == TCW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      prev_q <= line;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      data_o  <= '0;
      frm_o   <= 1'b0;
      perr_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!en_i) begin
        st_q   <= ST_IDLE;
        tcnt_q <= '0;
      end else begin
        case (st_q)
          ST_IDLE: if (prev_q && !line) begin  // falling edge only
            st_q   <= ST_START;
            tcnt_q <= '0;
          end
          ST_START: if (tick_i) begin
            if (mid_end) begin
              st_q   <= line ? ST_IDLE : ST_DATA;
              tcnt_q <= '0;
              idx_q  <= '0;
              data_o <= '0;
              perr_o <= 1'b0;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          default: if (tick_i) begin
            tcnt_q <= bit_end ? '0 : tcnt_q + 1'b1;
            if (bit_end) begin
              case (st_q)
                ST_DATA: begin
                  data_o[idx_q] <= line;
                  if (idx_q == last_idx) st_q <= par_en_i ? ST_PAR : ST_STOP;
                  else idx_q <= idx_q + 1'b1;
                end
                ST_PAR: begin
                  perr_o <= line ^ (^data_o) ^ ~even_i;
                  st_q   <= ST_STOP;
                end
                default: begin
                  frm_o   <= !line;
                  valid_o <= 1'b1;
                  st_q    <= ST_IDLE;
                end
              endcase
            end
          end
        endcase
      end
    end
  end

  a_r11_rx_quiet_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
endmodule

// File: rtl/sio_uart.sv
module sio_uart
  import sio_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 12,
  parameter int OVS        = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       tx_o,
  input  logic       rx_i,
  output logic       rx_irq_o,
  output logic       tx_irq_o
);
  localparam int DIV_HI_W = DIV_W - 8;
  localparam int RXW      = 11;  // {ovr, perr, frm, data}

  logic [7:0]          div_lo_q;
  logic [DIV_HI_W-1:0] div_hi_q;
  logic [DIV_W-1:0]    div, bcnt_q;
  lctl_t               lctl_q;
  logic                en_q, tick;
  logic [2:0]          stat_q;

  logic          wr_dat, rd_dat;
  logic          tx_pop, tx_empty, tx_full, tx_busy;
  logic [7:0]    tx_dout;
  logic          rx_valid, rx_frm, rx_perr, rx_empty, rx_full;
  logic [7:0]    rx_data;
  logic [RXW-1:0] rx_dout;

  assign wr_dat = sel_i && wr_i && (addr_i == A_DATA);
  assign rd_dat = sel_i && !wr_i && (addr_i == A_DATA);
  assign div    = {div_hi_q, div_lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_lo_q <= '0;
      div_hi_q <= '0;
      lctl_q   <= '0;
      en_q     <= 1'b0;
      stat_q   <= '0;
    end else begin
      if (sel_i && wr_i) begin
        case (addr_i)
          A_DIVL: div_lo_q <= wdata_i;
          A_DIVM: div_hi_q <= wdata_i[DIV_HI_W-1:0];
          A_LCTL: lctl_q   <= lctl_t'(wdata_i[6:0]);
          A_EN:   en_q     <= wdata_i[0];
          default: ;
        endcase
      end
      if (rd_dat && !rx_empty) stat_q <= rx_dout[RXW-1:8];
    end
  end

  // one tick every div+1 clocks, phase restarts on enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          bcnt_q <= '0;
    else if (!en_q)       bcnt_q <= '0;
    else if (bcnt_q == 0) bcnt_q <= div;
    else                  bcnt_q <= bcnt_q - 1'b1;
  end
  assign tick = en_q && (bcnt_q == '0);

  sio_fifo #(.W(8), .D(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni, .one_i(!lctl_q.fifo_en),
    .push_i(wr_dat), .din_i(wdata_i), .pop_i(tx_pop), .mark_i(1'b0),
    .dout_o(tx_dout), .empty_o(tx_empty), .full_o(tx_full)
  );

  sio_tx #(.OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .en_i(en_q), .tick_i(tick), .brk_i(lctl_q.brk),
    .wlen_i(lctl_q.wlen), .par_en_i(lctl_q.par_en), .even_i(lctl_q.even),
    .two_stop_i(lctl_q.two_stop), .avail_i(!tx_empty), .data_i(tx_dout),
    .pop_o(tx_pop), .tx_o, .busy_o(tx_busy)
  );

  sio_rx #(.OVS(OVS)) u_rx (
    .clk_i, .rst_ni, .en_i(en_q), .tick_i(tick), .rx_i,
    .wlen_i(lctl_q.wlen), .par_en_i(lctl_q.par_en), .even_i(lctl_q.even),
    .valid_o(rx_valid), .data_o(rx_data), .frm_o(rx_frm), .perr_o(rx_perr)
  );

  sio_fifo #(.W(RXW), .D(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .one_i(!lctl_q.fifo_en),
    .push_i(rx_valid), .din_i({1'b0, rx_perr, rx_frm, rx_data}),
    .pop_i(rd_dat), .mark_i(rx_valid && rx_full),
    .dout_o(rx_dout), .empty_o(rx_empty), .full_o(rx_full)
  );

  always_comb begin
    case (addr_i)
      A_DATA:  rdata_o = rx_empty ? 8'h00 : rx_dout[7:0];
      A_STAT:  rdata_o = {5'b0, stat_q};
      A_FLAG:  rdata_o = {2'b0, tx_full, rx_empty, tx_busy, 3'b0};
      A_DIVL:  rdata_o = div_lo_q;
      A_DIVM:  rdata_o = 8'(div_hi_q);
      A_LCTL:  rdata_o = {1'b0, lctl_q};
      A_EN:    rdata_o = {7'b0, en_q};
      default: rdata_o = 8'h00;
    endcase
  end

  assign rx_irq_o = en_q && !rx_empty;
  assign tx_irq_o = en_q && !tx_full;

  a_r12_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o || tx_irq_o) |-> $past(1'b1) && en_q);
endmodule

// File: tb/sio_uart_bench.sv
module sio_uart_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tx, rx_irq, tx_irq;
  logic       lb = 1'b1, drv = 1'b1;
  logic       rx;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  assign rx = lb ? tx : drv;
  always #4 clk = ~clk;

  sio_uart u_sio_uart (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_o(tx), .rx_i(rx),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a; #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic cfg(input logic [7:0] lctl);
    bus_wr(3'd6, 8'h00);
    bus_wr(3'd5, lctl);
    bus_wr(3'd6, 8'h01);
  endtask

  task automatic wait_rx(input string req);
    int t = 0;
    @(negedge clk); sel = 1; wr = 0; addr = 3'd2;
    #1;
    while (rdata[4] && t < 6000) begin @(negedge clk); #1; t++; end
    sel = 0;
    if (t >= 6000) chk(req, 1, 0);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one frame on the receive line at 16 clocks per bit
  task automatic raw_frame(input logic [7:0] d, input int nb, input bit pen,
                           input bit pbit, input bit stopv);
    @(negedge clk);
    drv = 0; repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin drv = d[i]; repeat (16) @(negedge clk); end
    if (pen) begin drv = pbit; repeat (16) @(negedge clk); end
    drv = stopv; repeat (16) @(negedge clk);
    drv = 1; repeat (16) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R13 tx idle high", tx, 1);
    chk("R13 rx_irq", rx_irq, 0);
    chk("R13 tx_irq", tx_irq, 0);
    bus_rd(3'd2, v); chk("R13 R5 flags", v, 8'h10);
    bus_rd(3'd1, v); chk("R13 status", v, 0);
    bus_rd(3'd0, v); chk("R3 empty read", v, 0);
    bus_rd(3'd3, v); chk("R13 div low", v, 0);
    bus_rd(3'd4, v); chk("R13 div mid", v, 0);
    bus_rd(3'd5, v); chk("R13 lctl", v, 0);
    bus_rd(3'd6, v); chk("R13 enable", v, 0);
  endtask

  task automatic t_formats;
    logic [7:0] v, d, lc, m;
    int cnt, t, nbits;
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 3; pm++)
        for (int sb = 0; sb < 2; sb++) begin
          lc = 8'h10 | 8'(wl << 5) | 8'(sb << 3);
          if (pm != 0) lc = lc | 8'h02 | ((pm == 2) ? 8'h04 : 8'h00);
          d  = 8'hA5 ^ 8'(wl * 37 + pm * 11 + sb * 5);
          m  = 8'hFF >> (3 - wl);
          nbits = 1 + wl + 5 + (pm != 0 ? 1 : 0) + 1 + sb;
          cfg(lc);
          bus_wr(3'd0, d);
          t = 0;
          while (tx !== 1'b0 && t < 100) begin @(negedge clk); t++; end
          @(negedge clk); sel = 1; wr = 0; addr = 3'd2; #1;
          cnt = 1;
          while (rdata[3] && cnt < 4000) begin @(negedge clk); #1; cnt++; end
          sel = 0;
          chk_win("R2 R5 frame length", cnt, nbits * 16 - 2, nbits * 16 + 2);
          wait_rx("R2 frame received");
          bus_rd(3'd0, v); chk("R2 R3 loopback data", v, d & m);
          bus_rd(3'd1, v); chk("R4 clean status", v, 0);
        end
  endtask

  task automatic t_baud;
    logic [7:0] v;
    int cnt, t;
    bus_wr(3'd6, 0); bus_wr(3'd3, 8'd2); bus_wr(3'd5, 8'h70); bus_wr(3'd6, 1);
    bus_wr(3'd0, 8'h01);
    t = 0;
    while (tx !== 1'b0 && t < 100) begin @(negedge clk); t++; end
    cnt = 0;
    while (tx === 1'b0 && cnt < 10000) begin @(negedge clk); cnt++; end
    chk_win("R1 bit time div 2", cnt, 45, 51);
    wait_rx("R1 frame at div 2");
    bus_rd(3'd0, v); chk("R1 data at div 2", v, 8'h01);
    bus_wr(3'd6, 0); bus_wr(3'd3, 8'd0); bus_wr(3'd4, 8'hF1);
    bus_rd(3'd4, v); chk("R1 mid divisor readback", v, 8'h01);
    bus_wr(3'd6, 1);
    bus_wr(3'd0, 8'h01);
    t = 0;
    while (tx !== 1'b0 && t < 100) begin @(negedge clk); t++; end
    cnt = 0;
    while (tx === 1'b0 && cnt < 10000) begin @(negedge clk); cnt++; end
    chk_win("R1 bit time div 256", cnt, 4112 - 258, 4112 + 2);
    bus_wr(3'd6, 0); bus_wr(3'd4, 8'h00);
  endtask

  task automatic t_rx_errors;
    logic [7:0] v;
    lb = 0;
    cfg(8'h76);  // 8 bits, even parity, FIFO on
    raw_frame(8'h3C, 8, 1, 1'b1, 1'b1);
    wait_rx("R9 parity frame");
    bus_rd(3'd0, v); chk("R9 data kept on parity error", v, 8'h3C);
    bus_rd(3'd1, v); chk("R4 R9 parity error bit", v, 8'h02);
    raw_frame(8'h81, 8, 1, 1'b0, 1'b0);
    wait_rx("R9 framing frame");
    bus_rd(3'd0, v); chk("R9 data kept on framing error", v, 8'h81);
    bus_rd(3'd1, v); chk("R4 R9 framing error bit", v, 8'h01);
    raw_frame(8'h81, 8, 1, 1'b0, 1'b1);
    wait_rx("R9 good frame");
    bus_rd(3'd0, v); chk("R9 good data", v, 8'h81);
    bus_rd(3'd1, v); chk("R4 good status", v, 8'h00);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    @(negedge clk); drv = 0; wait_cyc(4); drv = 1;
    wait_cyc(400);
    bus_rd(3'd2, v); chk("R8 glitch rejected", v[4], 1);
  endtask

  task automatic t_overrun_fifo;
    logic [7:0] v;
    cfg(8'h70);
    for (int i = 0; i < 17; i++) raw_frame(8'h40 + 8'(i), 8, 0, 0, 1);
    chk("R12 rx_irq with data", rx_irq, 1);
    for (int i = 0; i < 16; i++) begin
      bus_rd(3'd0, v); chk("R6 R7 fifo order", v, 8'h40 + 8'(i));
      bus_rd(3'd1, v); chk("R7 overrun on newest only", v, (i == 15) ? 8'h04 : 8'h00);
    end
    bus_rd(3'd2, v); chk("R7 extra frame discarded", v[4], 1);
    chk("R12 rx_irq drained", rx_irq, 0);
  endtask

  task automatic t_overrun_single;
    logic [7:0] v;
    cfg(8'h60);
    raw_frame(8'h11, 8, 0, 0, 1);
    raw_frame(8'h22, 8, 0, 0, 1);
    bus_rd(3'd0, v); chk("R6 R7 depth one keeps first", v, 8'h11);
    bus_rd(3'd1, v); chk("R7 depth one overrun", v, 8'h04);
    bus_rd(3'd2, v); chk("R6 depth one empty after", v[4], 1);
  endtask

  task automatic t_break;
    logic [7:0] v;
    lb = 0;
    cfg(8'h71);
    wait_cyc(5);
    chk("R10 line low in break", tx, 0);
    bus_wr(3'd0, 8'h5A);
    wait_cyc(400);
    bus_rd(3'd2, v); chk("R10 no start in break", v[3], 0);
    chk("R10 still low", tx, 0);
    lb = 1;
    bus_wr(3'd5, 8'h70);
    wait_rx("R10 resume");
    bus_rd(3'd0, v); chk("R10 queued char sent", v, 8'h5A);
    bus_rd(3'd1, v); chk("R10 clean after break", v, 0);
  endtask

  task automatic t_disable_depth;
    logic [7:0] v;
    bus_wr(3'd6, 0); bus_wr(3'd5, 8'h70);
    lb = 0;
    raw_frame(8'h33, 8, 0, 0, 1);
    bus_rd(3'd2, v); chk("R11 rx ignores line", v[4], 1);
    lb = 1;
    for (int i = 0; i < 16; i++) bus_wr(3'd0, 8'h80 + 8'(i));
    bus_rd(3'd2, v); chk("R6 tx full at 16", v[5], 1);
    chk("R11 tx_irq gated", tx_irq, 0);
    bus_wr(3'd0, 8'h99);
    wait_cyc(300);
    chk("R11 line idle when disabled", tx, 1);
    bus_rd(3'd2, v); chk("R11 not shifting", v[3], 0);
    bus_wr(3'd6, 1);
    wait_cyc(2);
    chk("R12 tx_irq with room", tx_irq, 1);
    wait_cyc(16 * 160 + 300);
    chk("R12 rx_irq set", rx_irq, 1);
    for (int i = 0; i < 16; i++) begin
      bus_rd(3'd0, v); chk("R6 16 deep order", v, 8'h80 + 8'(i));
    end
    bus_rd(3'd2, v); chk("R6 write to full dropped", v[4], 1);
    bus_wr(3'd6, 0); bus_wr(3'd5, 8'h60);
    bus_wr(3'd0, 8'h44);
    bus_rd(3'd2, v); chk("R6 depth one full", v[5], 1);
    bus_wr(3'd6, 1);
    wait_rx("R6 depth one send");
    bus_rd(3'd0, v); chk("R6 depth one data", v, 8'h44);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    t_reset();
    t_formats();
    t_baud();
    t_rx_errors();
    t_glitch();
    t_overrun_fifo();
    t_overrun_single();
    t_break();
    t_disable_depth();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule